// File: doc/BRIEF.md
# Audio master clock generator

Two master clock outputs for audio serial ports come from this block. Each output has its own path. It picks one of several system clock sources, divides that source by a programmable ratio, and then either drives the divided clock onto its pin or parks the pin at logic high. All sources are modelled as single-cycle enables in one fast clock domain (`clk`). Each output also has a one-cycle strobe that marks every divided tick, and neighbouring serial ports use it as their timing reference.

All settings for both paths sit in one 32-bit control word, written through a plain write strobe. Each path keeps a private copy of its source select and ratio. While the path runs, that copy is refreshed only at the end of a divided period. A ratio or source change therefore never cuts a period short. While the path is stopped, the copy follows the register freely.

Top module: `amclk_gen`

## Requirements
- R1: During and after reset, with no write yet, both `mclk` bits are 1 and both `mclk_stb` bits are 0.
- R2: A write (`ctrl_we`=1 at a rising edge) loads these fields. Output-0 mode is bits 15:14 and output-1 mode is bits 13:12. The ratio for output 0 is bits 23:20 and for output 1 is bits 19:16. The source select for output 0 is bits 30:28 and for output 1 is bits 26:24. Bits 31, 27 and 11:0 have no effect.
- R3: With mode 1, source period P cycles and ratio N, the strobes of a path are spaced exactly P*(N+1) cycles apart once the first has occurred. `mclk` inverts on the same edge as each strobe.
- R4: After a path is started from the stopped state, its first strobe coincides with `mclk` going from 1 to 0.
- R5: Mode 0 forces that `mclk` bit to 1 and its strobe to 0 from the second rising edge after the write onward.
- R6: Modes 2 and 3 behave exactly like mode 0.
- R7: A source select value of `NUM_SRC` or more (4 to 7 by default) produces no strobes, and the output stays at 1.
- R8: While a path runs, a new ratio or select takes effect only at the end of the divided period in progress. That period completes at its old length.
- R9: The two paths run independently, each at its own select and ratio.
- R10: Source k is `sys_ce[k]`. Select value k counts enables of that bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that all logic runs on |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Loads `ctrl_wdata` into the control register |
| ctrl_wdata | input | 32 | Control word holding both paths' fields |
| sys_ce | input | NUM_SRC | One enable per system clock source |
| mclk | output | 2 | Master clock outputs; bit i belongs to path i |
| mclk_stb | output | 2 | One-cycle strobe per divided tick of each path |

## Verification
The critical overlap is a control write landing in the same cycle as a divided terminal count, or while one is pending. The bench provokes this in two ways on a running path. One write is issued in the cycle right after a strobe is seen, and another is issued in the middle of a period. Both writes change the ratio and the source at the same time. In each case the interval ending at the next strobe must keep the old length. The steady interval after it must match the new source period times the new ratio plus one.

// File: rtl/amclk_pkg.sv
package amclk_pkg;

   localparam int SEL_W   = 3;
   localparam int RATIO_W = 4;
   localparam int NUM_CH  = 2;
   localparam int MAX_SRC = 1 << SEL_W;

   typedef enum logic [1:0] {
      OUT_OFF   = 2'd0,
      OUT_RUN   = 2'd1,
      OUT_RSV_A = 2'd2,
      OUT_RSV_B = 2'd3
   } out_code_e;

   typedef struct packed {
      out_code_e            code;
      logic [RATIO_W-1:0]   ratio;
      logic [SEL_W-1:0]     sel;
   } chan_cfg_t;

endpackage

// File: rtl/amclk_cfg_reg.sv
module amclk_cfg_reg
   import amclk_pkg::*;
#(
   parameter int SEL_RESET   = 2,
   parameter int RATIO_RESET = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [31:0]             wdata,
   output chan_cfg_t [NUM_CH-1:0]  cfg
);

   localparam logic [SEL_W-1:0]   SEL_RST   = SEL_W'(SEL_RESET);
   localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(RATIO_RESET);

   chan_cfg_t [NUM_CH-1:0] cfg_q;
   chan_cfg_t [NUM_CH-1:0] cfg_d;

   logic unused_bits;
   assign unused_bits = ^{wdata[31], wdata[27], wdata[11:0]};

   always_comb begin
      cfg_d[0].code  = out_code_e'(wdata[15:14]);
      cfg_d[0].ratio = wdata[23:20];
      cfg_d[0].sel   = wdata[30:28];
      cfg_d[1].code  = out_code_e'(wdata[13:12]);
      cfg_d[1].ratio = wdata[19:16];
      cfg_d[1].sel   = wdata[26:24];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) begin
            cfg_q[i].code  <= OUT_OFF;
            cfg_q[i].ratio <= RATIO_RST;
            cfg_q[i].sel   <= SEL_RST;
         end
      end else if (we) begin
         cfg_q <= cfg_d;
      end
   end

   assign cfg = cfg_q;

   // R2: register changes only on a write
   assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cfg_q));

endmodule

// File: rtl/amclk_divider.sv
module amclk_divider
   import amclk_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_ce,
   input  chan_cfg_t          cfg,
   output logic               tick,
   output logic               sel_ok
);

   logic [MAX_SRC-1:0] src_pad;
   logic               run_q;
   logic [SEL_W-1:0]   act_sel;
   logic [RATIO_W-1:0] act_ratio;
   logic [RATIO_W-1:0] cnt;
   logic               src_hit;

   generate
      if (NUM_SRC < MAX_SRC) begin : g_padded
         assign src_pad = {{(MAX_SRC-NUM_SRC){1'b0}}, src_ce};
         assign sel_ok  = ({1'b0, act_sel} < (SEL_W+1)'(NUM_SRC));
      end else begin : g_full
         assign src_pad = src_ce;
         assign sel_ok  = 1'b1;
      end
   endgenerate

   assign src_hit = sel_ok && src_pad[act_sel];
   assign tick    = run_q && src_hit && (cnt == act_ratio);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         act_sel   <= '0;
         act_ratio <= '0;
         cnt       <= '0;
      end else begin
         run_q <= (cfg.code == OUT_RUN);
         if (!run_q || tick) begin
            act_sel   <= cfg.sel;
            act_ratio <= cfg.ratio;
            cnt       <= '0;
         end else if (src_hit) begin
            cnt <= cnt + RATIO_W'(1);
         end
      end
   end

   // R8: a running path keeps its settings until the terminal count
   assert_hold_until_terminal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick) |=> ($stable(act_sel) && $stable(act_ratio)));

   // R3: counter never passes the active ratio
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt <= act_ratio));

   // R7: a missing source yields no tick
   assert_no_tick_bad_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |-> !tick);

endmodule

// File: rtl/amclk_gate.sv
module amclk_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sel_ok,
   input  logic tick,
   output logic mclk,
   output logic stb
);

   logic mclk_q;
   logic stb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mclk_q <= 1'b1;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= tick && en;
         if (!en || !sel_ok)
            mclk_q <= 1'b1;
         else if (tick)
            mclk_q <= ~mclk_q;
      end
   end

   assign mclk = mclk_q;
   assign stb  = stb_q;

   // R5 / R6: a stopped path parks high with no strobe
   assert_park_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (mclk_q && !stb_q));

   // R7: missing source keeps the output high
   assert_bad_sel_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |=> mclk_q);

   // R3: a falling edge only comes with a strobe
   assert_fall_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclk_q && $past(mclk_q)) |-> stb_q);

endmodule

// File: rtl/amclk_gen.sv
module amclk_gen
   import amclk_pkg::*;
#(
   parameter int NUM_SRC     = 4,
   parameter int SEL_RESET   = 2,
   parameter int RATIO_RESET = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic [31:0]        ctrl_wdata,
   input  logic [NUM_SRC-1:0] sys_ce,
   output logic [NUM_CH-1:0]  mclk,
   output logic [NUM_CH-1:0]  mclk_stb
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
         $error("NUM_SRC must lie between 1 and the select range");
      end
      if (SEL_RESET < 0 || SEL_RESET >= MAX_SRC) begin : g_bad_sel_rst
         $error("SEL_RESET does not fit the select field");
      end
      if (RATIO_RESET < 0 || RATIO_RESET >= (1 << RATIO_W)) begin : g_bad_ratio_rst
         $error("RATIO_RESET does not fit the ratio field");
      end
   endgenerate

   chan_cfg_t [NUM_CH-1:0] cfg;

   amclk_cfg_reg #(
      .SEL_RESET   (SEL_RESET),
      .RATIO_RESET (RATIO_RESET)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .wdata (ctrl_wdata),
      .cfg   (cfg)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_path
         logic tick;
         logic sel_ok;
         logic en;

         assign en = (cfg[ch].code == OUT_RUN);

         amclk_divider #(.NUM_SRC(NUM_SRC)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_ce (sys_ce),
            .cfg    (cfg[ch]),
            .tick   (tick),
            .sel_ok (sel_ok)
         );

         amclk_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .sel_ok (sel_ok),
            .tick   (tick),
            .mclk   (mclk[ch]),
            .stb    (mclk_stb[ch])
         );
      end
   endgenerate

endmodule

// File: tb/tb_amclk_gen.sv
module tb_amclk_gen;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctrl_we = 1'b0;
   logic [31:0]     ctrl_wdata = '0;
   logic [NSRC-1:0] sys_ce = '0;
   logic [1:0]      mclk;
   logic [1:0]      mclk_stb;

   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   bit     done = 0;

   amclk_gen #(.NUM_SRC(NSRC)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .sys_ce     (sys_ce),
      .mclk       (mclk),
      .mclk_stb   (mclk_stb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk)
      for (int k = 0; k < NSRC; k++) sys_ce[k] <= ((cyc % (k + 1)) == 0);

   function automatic logic [31:0] mk(int c0, int c1, int r0, int r1, int s0, int s1);
      logic [31:0] w = '0;
      w[15:14] = c0[1:0];
      w[13:12] = c1[1:0];
      w[23:20] = r0[3:0];
      w[19:16] = r1[3:0];
      w[30:28] = s0[2:0];
      w[26:24] = s1[2:0];
      return w;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] w);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = w;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wait_stb(int ch, output longint t, output bit ok);
      ok = 0;
      t = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (mclk_stb[ch]) begin
            ok = 1;
            t = cyc;
            return;
         end
      end
   endtask

   task automatic quiet(int ch, int n, output int nstb, output int nlow);
      nstb = 0;
      nlow = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mclk_stb[ch]) nstb++;
         if (!mclk[ch]) nlow++;
      end
   endtask

   task automatic sweep(int ch);
      longint t, prev;
      bit ok;
      for (int s = 0; s < NSRC; s++) begin
         for (int n = 0; n < 16; n++) begin
            if (ch == 0) begin
               wr(mk(0, 0, n, 0, s, 0));
               wr(mk(1, 0, n, 0, s, 0));
            end else begin
               wr(mk(0, 0, 0, n, 0, s));
               wr(mk(0, 1, 0, n, 0, s));
            end
            wait_stb(ch, t, ok);
            chk(ok, "R3", "first strobe seen", ok, 1);
            chk(mclk[ch] == 1'b0, "R4", "mclk low at first strobe", mclk[ch], 0);
            prev = t;
            for (int k = 1; k < 4; k++) begin
               wait_stb(ch, t, ok);
               chk(ok && (t - prev) == (s + 1) * (n + 1), "R3_R10", "strobe spacing",
                   t - prev, (s + 1) * (n + 1));
               chk(mclk[ch] == k[0], "R3", "mclk toggles at strobe", mclk[ch], k[0]);
               prev = t;
            end
         end
      end
   endtask

   initial begin
      #(longint'(CLK_PERIOD) * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      longint t0, t1, t2, t3;
      bit ok;
      int nstb, nlow;

      // R1: reset state
      repeat (5) @(negedge clk);
      chk(mclk == 2'b11 && mclk_stb == 2'b00, "R1", "outputs in reset", {mclk, mclk_stb}, 4'b1100);
      rst_n = 1'b1;
      quiet(0, 30, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R1", "ch0 idle after reset", nstb + nlow, 0);
      quiet(1, 30, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R1", "ch1 idle after reset", nstb + nlow, 0);

      // R3 R4 R10: sweeps over all sources and ratios
      sweep(0);
      sweep(1);

      // R2: unused bits ignored, ch1 untouched
      wr(mk(0, 0, 1, 0, 1, 0) | 32'h8800_0FFF);
      wr(mk(1, 0, 1, 0, 1, 0) | 32'h8800_0FFF);
      wait_stb(0, t0, ok);
      wait_stb(0, t1, ok);
      chk(ok && (t1 - t0) == 4, "R2", "spacing with junk bits", t1 - t0, 4);
      quiet(1, 40, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R2", "ch1 unaffected by junk bits", nstb + nlow, 0);

      // R9: both paths at once
      wr(mk(0, 0, 2, 4, 1, 3));
      wr(mk(1, 1, 2, 4, 1, 3));
      wait_stb(0, t0, ok);
      wait_stb(0, t1, ok);
      chk(ok && (t1 - t0) == 6, "R9", "ch0 spacing concurrent", t1 - t0, 6);
      wait_stb(1, t0, ok);
      wait_stb(1, t1, ok);
      chk(ok && (t1 - t0) == 20, "R9", "ch1 spacing concurrent", t1 - t0, 20);

      // R8: mid-period change of ratio and source
      wr(mk(0, 0, 7, 0, 0, 0));
      wr(mk(1, 0, 7, 0, 0, 0));
      wait_stb(0, t0, ok);
      wait_stb(0, t0, ok);
      repeat (2) @(negedge clk);
      wr(mk(1, 0, 2, 0, 1, 0));
      wait_stb(0, t1, ok);
      chk(ok && (t1 - t0) == 8, "R8", "period in progress keeps old length", t1 - t0, 8);
      wait_stb(0, t2, ok);
      wait_stb(0, t3, ok);
      chk(ok && (t3 - t2) == 6, "R8", "new spacing after terminal count", t3 - t2, 6);

      // R8: write right after a seen strobe
      wr(mk(1, 0, 4, 0, 0, 0));
      wait_stb(0, t0, ok);
      wait_stb(0, t0, ok);
      wait_stb(0, t0, ok);
      ctrl_we = 1'b1;
      ctrl_wdata = mk(1, 0, 1, 0, 3, 0);
      @(negedge clk);
      ctrl_we = 1'b0;
      wait_stb(0, t1, ok);
      chk(ok && (t1 - t0) == 5, "R8", "write next to strobe keeps old length", t1 - t0, 5);
      wait_stb(0, t2, ok);
      wait_stb(0, t3, ok);
      chk(ok && (t3 - t2) == 8, "R8", "spacing after coincident write", t3 - t2, 8);

      // R5: stop a running path
      wr(mk(1, 0, 3, 0, 0, 0));
      wait_stb(0, t0, ok);
      wait_stb(0, t0, ok);
      wr(mk(0, 0, 3, 0, 0, 0));
      @(negedge clk);
      chk(mclk[0] == 1'b1 && mclk_stb[0] == 1'b0, "R5", "parked two edges after write",
          {mclk[0], mclk_stb[0]}, 2'b10);
      quiet(0, 40, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R5", "stays parked", nstb + nlow, 0);

      // R6: reserved modes
      wr(mk(2, 3, 0, 0, 0, 0));
      quiet(0, 60, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R6", "mode 2 parked", nstb + nlow, 0);
      quiet(1, 60, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R6", "mode 3 parked", nstb + nlow, 0);
      wr(mk(3, 2, 0, 0, 0, 0));
      quiet(0, 40, nstb, nlow);
      chk(nstb == 0 && nlow == 0, "R6", "mode 3 parked ch0", nstb + nlow, 0);

      // R7: selects without a source
      for (int s = NSRC; s < 8; s++) begin
         wr(mk(0, 0, 0, 1, s, s));
         wr(mk(1, 1, 0, 1, s, s));
         quiet(0, 50, nstb, nlow);
         chk(nstb == 0 && nlow == 0, "R7", "ch0 missing source", nstb + nlow, 0);
         quiet(1, 50, nstb, nlow);
         chk(nstb == 0 && nlow == 0, "R7", "ch1 missing source", nstb + nlow, 0);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule